// File: doc/BRIEF.md
# Rectangle Copy Command Stream Generator

This block turns one copy request into the command words a 2D copy engine needs to move a rectangle of 32-bit pixels from one surface to another. A single-cycle start pulse latches the configuration: an addressing flag that selects 64-bit addresses, a tiling mode for each surface, the rectangle size in pixels, and the two base addresses. The block then presents the words one at a time on a valid/ready stream.

The stream has three parts. A register write sets the per-surface Y-tiling controls. A flush follows. Then comes the copy command, whose length field, pitches, tiled flags and address words depend on the latched configuration. A batch-end word closes the stream, and a one-cycle done pulse follows the last accepted word. All opcode values, the register offset, the format bits and the bit positions of the flags are parameters.

Top module: `blit_copy_emitter`

## Requirements
- R1: After reset, `word_valid_o` and `done_o` are low.
- R2: A stream is 16 words with `wide_i`=0 and 18 words with `wide_i`=1. The words are, in order: register-write header `LRI_CMD`, register offset `CTRL_REG`, control word, flush command, three zero words, copy header, format/destination-pitch word, zero word, size word, destination address low, destination address high (wide only), zero word, source pitch, source address low, source address high (wide only), and `END_CMD`.
- R3: Bits [16+`SRC_Y_BIT`] and [16+`DST_Y_BIT`] of the control word are always 1. Bit `SRC_Y_BIT` or `DST_Y_BIT` is 1 only when that surface's tiling code is 2 (Y tiling). All other bits are 0.
- R4: The flush word is `FLUSH_CMD`, plus 1 when wide. It is followed by three zero words.
- R5: The copy header is `COPY_CMD` + 6, plus 2 more when wide. It is ORed with bit `SRC_TILED_BIT` when the source tiling code is nonzero, and with bit `DST_TILED_BIT` when the destination tiling code is nonzero.
- R6: A surface's pitch is width×4 when its tiling code is 0, and width when it is nonzero. The destination pitch is ORed into `FMT_BITS`. The source pitch is sent as its own word.
- R7: The size word is {height, width}. Each address is sent as its low 32 bits, followed by its high 32 bits only when wide.
- R8: `done_o` is high for exactly one cycle, the cycle after the `END_CMD` word is accepted. `word_valid_o` is low in that cycle.
- R9: While `word_valid_o` is high and `word_ready_i` is low, the word and valid are held unchanged. No word is dropped or repeated.
- R10: A start pulse while a stream is in progress is ignored. Inputs other than `start_i` have no effect on a stream once it has started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a stream; latches the configuration |
| wide_i | input | 1 | Select 64-bit addressing |
| src_tile_i | input | 2 | Source tiling: 0 linear, 1 X, 2 Y, 3 other tiled |
| dst_tile_i | input | 2 | Destination tiling, same coding |
| width_i | input | 16 | Rectangle width in pixels |
| height_i | input | 16 | Rectangle height in pixels |
| src_addr_i | input | 64 | Source base address |
| dst_addr_i | input | 64 | Destination base address |
| word_o | output | 32 | Current command word |
| word_valid_o | output | 1 | Word is valid |
| word_ready_i | input | 1 | Consumer accepts the word |
| done_o | output | 1 | One-cycle pulse after the final word |

## Verification
The generator is tried with narrow addressing on two linear surfaces. It is also tried with wide addressing on an X-tiled source and a Y-tiled destination, and on a Y-tiled source and a linear destination. A run with code 3 on both surfaces separates "tiled" from "Y-tiled". These cases show whether the word count, the length fields, each pitch scaling and each flag are driven by the right surface and the right mode. The consumer's ready is held high, toggled, and stalled two cycles out of three, which exposes any dropped, repeated or changed word under backpressure. One run pulses start and changes every input mid-stream to confirm the captured configuration is kept.

// File: rtl/blit_copy_emitter.sv
module blit_copy_emitter #(
  parameter logic [31:0] LRI_CMD       = 32'h1100_0001,
  parameter logic [31:0] CTRL_REG      = 32'h0002_2200,
  parameter int          SRC_Y_BIT     = 0,
  parameter int          DST_Y_BIT     = 1,
  parameter logic [31:0] FLUSH_CMD     = 32'h1300_0002,
  parameter logic [31:0] COPY_CMD      = 32'h5430_0000,
  parameter int          SRC_TILED_BIT = 15,
  parameter int          DST_TILED_BIT = 11,
  parameter logic [31:0] FMT_BITS      = 32'h03CC_0000,
  parameter logic [31:0] END_CMD       = 32'h0500_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        wide_i,
  input  logic [1:0]  src_tile_i,
  input  logic [1:0]  dst_tile_i,
  input  logic [15:0] width_i,
  input  logic [15:0] height_i,
  input  logic [63:0] src_addr_i,
  input  logic [63:0] dst_addr_i,
  output logic [31:0] word_o,
  output logic        word_valid_o,
  input  logic        word_ready_i,
  output logic        done_o
);
  localparam int LAST_NARROW = 15;
  localparam int LAST_WIDE   = 17;

  logic        busy;
  logic [4:0]  idx, slot;
  logic        c_wide;
  logic [1:0]  c_stile, c_dtile;
  logic [15:0] c_w, c_h;
  logic [63:0] c_src, c_dst;

  wire fire = busy && word_ready_i;
  wire last = idx == (c_wide ? 5'(LAST_WIDE) : 5'(LAST_NARROW));

  function automatic logic [31:0] pitch(input logic [1:0] t, input logic [15:0] w);
    return (t != 2'd0) ? {16'd0, w} : {14'd0, w, 2'b00};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx <= '0;
      done_o <= 1'b0;
      c_wide <= 1'b0;
      c_stile <= '0;
      c_dtile <= '0;
      c_w <= '0;
      c_h <= '0;
      c_src <= '0;
      c_dst <= '0;
    end else begin
      done_o <= fire && last;
      if (!busy && start_i) begin
        busy <= 1'b1;
        idx <= '0;
        c_wide <= wide_i;
        c_stile <= src_tile_i;
        c_dtile <= dst_tile_i;
        c_w <= width_i;
        c_h <= height_i;
        c_src <= src_addr_i;
        c_dst <= dst_addr_i;
      end else if (fire) begin
        if (last) busy <= 1'b0;
        else idx <= idx + 5'd1;
      end
    end
  end

  always_comb begin
    if (c_wide || idx < 5'd12) slot = idx;
    else if (idx == 5'd15)     slot = 5'd17;
    else                       slot = idx + 5'd1;
  end

  logic [31:0] ctrl, copy_hdr;
  assign ctrl = (32'(1) << (16 + SRC_Y_BIT)) | (32'(1) << (16 + DST_Y_BIT))
              | ((c_stile == 2'd2) ? (32'(1) << SRC_Y_BIT) : 32'd0)
              | ((c_dtile == 2'd2) ? (32'(1) << DST_Y_BIT) : 32'd0);
  assign copy_hdr = (COPY_CMD + (c_wide ? 32'd8 : 32'd6))
                  | ((c_stile != 2'd0) ? (32'(1) << SRC_TILED_BIT) : 32'd0)
                  | ((c_dtile != 2'd0) ? (32'(1) << DST_TILED_BIT) : 32'd0);

  always_comb begin
    case (slot)
      5'd0:  word_o = LRI_CMD;
      5'd1:  word_o = CTRL_REG;
      5'd2:  word_o = ctrl;
      5'd3:  word_o = FLUSH_CMD + {31'd0, c_wide};
      5'd7:  word_o = copy_hdr;
      5'd8:  word_o = FMT_BITS | pitch(c_dtile, c_w);
      5'd10: word_o = {c_h, c_w};
      5'd11: word_o = c_dst[31:0];
      5'd12: word_o = c_dst[63:32];
      5'd14: word_o = pitch(c_stile, c_w);
      5'd15: word_o = c_src[31:0];
      5'd16: word_o = c_src[63:32];
      5'd17: word_o = END_CMD;
      default: word_o = 32'd0;
    endcase
  end

  assign word_valid_o = busy;

  logic [4:0] hs_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hs_cnt <= '0;
    else if (done_o) hs_cnt <= '0;
    else if (word_valid_o && word_ready_i) hs_cnt <= hs_cnt + 5'd1;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_o));
  assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> hs_cnt == (c_wide ? 5'd18 : 5'd16));
  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !word_valid_o && $past(word_valid_o && word_ready_i && word_o == END_CMD));
  assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid_o) |-> $past(start_i));
endmodule

// File: tb/blit_copy_emitter_tb.sv
module blit_copy_emitter_tb;
  localparam logic [31:0] LRI_CMD   = 32'h1100_0001;
  localparam logic [31:0] CTRL_REG  = 32'h0002_2200;
  localparam int          SYB = 0, DYB = 1, STB = 15, DTB = 11;
  localparam logic [31:0] FLUSH_CMD = 32'h1300_0002;
  localparam logic [31:0] COPY_CMD  = 32'h5430_0000;
  localparam logic [31:0] FMT_BITS  = 32'h03CC_0000;
  localparam logic [31:0] END_CMD   = 32'h0500_0000;

  logic clk = 0, rst_n = 0, start_i = 0, wide_i = 0, word_ready_i = 0;
  logic [1:0] src_tile_i = 0, dst_tile_i = 0;
  logic [15:0] width_i = 0, height_i = 0;
  logic [63:0] src_addr_i = 0, dst_addr_i = 0;
  logic [31:0] word_o;
  logic word_valid_o, done_o;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  blit_copy_emitter #(.LRI_CMD(LRI_CMD), .CTRL_REG(CTRL_REG), .SRC_Y_BIT(SYB),
    .DST_Y_BIT(DYB), .FLUSH_CMD(FLUSH_CMD), .COPY_CMD(COPY_CMD), .SRC_TILED_BIT(STB),
    .DST_TILED_BIT(DTB), .FMT_BITS(FMT_BITS), .END_CMD(END_CMD)) u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] exp_w [18];
  string exp_r [18];
  int exp_n;

  task automatic build(input bit wd, input logic [1:0] st, input logic [1:0] dt,
                       input logic [15:0] w, input logic [15:0] h,
                       input logic [63:0] sa, input logic [63:0] da);
    logic [31:0] sp, dp, ctl, hdr;
    int k = 0;
    sp = (st != 0) ? 32'(w) : 32'(w) * 4;
    dp = (dt != 0) ? 32'(w) : 32'(w) * 4;
    ctl = 32'h3 << 16;
    if (st == 2) ctl |= 32'h1;
    if (dt == 2) ctl |= 32'h2;
    hdr = COPY_CMD + (wd ? 8 : 6);
    if (st != 0) hdr |= 32'h8000;
    if (dt != 0) hdr |= 32'h0800;
    exp_w[k] = LRI_CMD;   exp_r[k++] = "R2";
    exp_w[k] = CTRL_REG;  exp_r[k++] = "R2";
    exp_w[k] = ctl;       exp_r[k++] = "R3";
    exp_w[k] = FLUSH_CMD + (wd ? 1 : 0); exp_r[k++] = "R4";
    for (int i = 0; i < 3; i++) begin exp_w[k] = 0; exp_r[k++] = "R4"; end
    exp_w[k] = hdr;            exp_r[k++] = "R5";
    exp_w[k] = FMT_BITS | dp;  exp_r[k++] = "R6";
    exp_w[k] = 0;              exp_r[k++] = "R2";
    exp_w[k] = {h, w};         exp_r[k++] = "R7";
    exp_w[k] = da[31:0];       exp_r[k++] = "R7";
    if (wd) begin exp_w[k] = da[63:32]; exp_r[k++] = "R7"; end
    exp_w[k] = 0;              exp_r[k++] = "R2";
    exp_w[k] = sp;             exp_r[k++] = "R6";
    exp_w[k] = sa[31:0];       exp_r[k++] = "R7";
    if (wd) begin exp_w[k] = sa[63:32]; exp_r[k++] = "R7"; end
    exp_w[k] = END_CMD;        exp_r[k++] = "R8";
    exp_n = k;
  endtask

  // pattern: 0 always ready, 1 alternate, 2 ready one cycle in three
  task automatic run(input bit wd, input logic [1:0] st, input logic [1:0] dt,
                     input logic [15:0] w, input logic [15:0] h,
                     input logic [63:0] sa, input logic [63:0] da,
                     input int pat, input bit disturb);
    int got = 0, cyc = 0;
    logic [31:0] prev_w = 0;
    bit prev_stall = 0;
    build(wd, st, dt, w, h, sa, da);
    @(negedge clk);
    wide_i = wd; src_tile_i = st; dst_tile_i = dt; width_i = w; height_i = h;
    src_addr_i = sa; dst_addr_i = da; start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (got < exp_n && cyc < 200) begin
      case (pat)
        0: word_ready_i = 1;
        1: word_ready_i = cyc[0];
        default: word_ready_i = (cyc % 3 == 2);
      endcase
      if (disturb && cyc == 4) begin
        start_i = 1; wide_i = ~wd; src_tile_i = 2'd3; dst_tile_i = 2'd3;
        width_i = 16'h1234; height_i = 16'h5678; src_addr_i = '1; dst_addr_i = '1;
      end else start_i = 0;
      #1;
      if (prev_stall)
        check(word_valid_o && word_o == prev_w, "R9 hold", word_o, prev_w);
      if (word_valid_o && word_ready_i) begin
        check(word_o == exp_w[got], disturb ? "R10 word" : exp_r[got], word_o, exp_w[got]);
        got++;
      end
      prev_stall = word_valid_o && !word_ready_i;
      prev_w = word_o;
      cyc++;
      @(negedge clk);
    end
    start_i = 0;
    word_ready_i = 0;
    check(got == exp_n, "R2 count", 32'(got), 32'(exp_n));
    #1;
    check(done_o == 1 && word_valid_o == 0, "R8 done pulse", {30'd0, done_o, word_valid_o}, 32'h2);
    @(negedge clk); #1;
    check(done_o == 0 && word_valid_o == 0, "R8 done single", {30'd0, done_o, word_valid_o}, 32'h0);
  endtask

  task automatic t_reset();
    #1;
    check(!word_valid_o && !done_o, "R1 reset", {30'd0, word_valid_o, done_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    run(0, 0, 0, 16'd512, 16'd32, 64'h0000_0001_0000_4000, 64'h0000_0002_0008_0000, 0, 0);
    run(1, 1, 2, 16'd100, 16'd7, 64'hAAAA_0001_1234_0000, 64'h5555_0002_0000_8000, 1, 0);
    run(1, 2, 0, 16'd640, 16'd480, 64'h0000_00FF_0010_0000, 64'h0000_0000_0020_0000, 2, 0);
    run(0, 3, 3, 16'd1, 16'd1, 64'h1, 64'h2, 2, 0);
    run(0, 0, 1, 16'd64, 16'd9, 64'h0000_0000_CAFE_0000, 64'h0000_0000_BEEF_0000, 1, 1);
    run(1, 0, 0, 16'hFFFF, 16'hFFFF, 64'hFFFF_FFFF_FFFF_F000, 64'h8000_0000_0000_0000, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule